// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Transmitter

This block serialises one byte plus a separately supplied ninth bit into an
eleven-bit asynchronous frame on a single output line. The frame begins with a low
start bit. The eight data bits follow, least significant first, then the ninth
bit, and the frame ends with a high stop bit. The line rests high whenever no frame
is being sent.

Bit timing comes from two counters. A prescaler turns the oscillator clock into a
tick at sixteen times the baud rate. A free-running modulo-16 slice counter counts
those ticks and pulses once per wrap. With the rate select high, a bit lasts 32
oscillator clocks. With it low, a bit lasts 64 clocks.

The bit boundaries depend only on the slice counter, which runs from reset. A byte
write only arms the transmitter. The start bit goes out on the next wrap, and each
later bit goes out on the wrap after that. A completion flag rises on the wrap that
drives the stop bit, and it stays high until the host clears it.

Top module: `ser9_tx`

## Requirements
- R1: While reset is held and after it is released with no write, `txd` is 1 and `tx_done` is 0.
- R2: A frame on `txd` is, in time order: a 0 start bit, `wr_data[0]` through `wr_data[7]`, the ninth bit, and a 1 stop bit, after which the line stays at 1.
- R3: Every bit lasts exactly 32 clock cycles when `fast_rate` is 1 and exactly 64 clock cycles when it is 0. The rate select must stay constant from reset through the frame.
- R4: Slice-counter wraps take effect at clock edges k·P−1 after reset release, counting the first edge with reset low as edge 0, where P is the bit length in clocks. The start bit appears at the first wrap edge strictly later than the edge that captures the write, so a write captured on a wrap edge waits one full bit period.
- R5: `tx_done` becomes 1 on the same edge that drives the stop bit, which is the eleventh wrap counted from the one that drives the start bit, and it is 0 before that edge.
- R6: Once set, `tx_done` stays 1 until `done_clr` is sampled high, and it then reads 0 on the following cycle.
- R7: When `done_clr` is high on the edge that sets `tx_done`, the set wins and `tx_done` reads 1 afterwards.
- R8: A write strobe while a frame is armed or being sent is ignored: the frame on `txd` continues unchanged.
- R9: The ninth bit is captured from `bit9_in` on the write edge. Later changes of `bit9_in` do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_rate | input | 1 | 1: 16x tick every 2 clocks; 0: every 4 clocks |
| wr_stb | input | 1 | One-cycle strobe that loads a byte for sending |
| wr_data | input | 8 | Byte to send, LSB first |
| bit9_in | input | 1 | Ninth bit, captured with the write |
| done_clr | input | 1 | Clears the completion flag |
| txd | output | 1 | Serial output line, idle high |
| tx_done | output | 1 | Completion flag, set with the stop bit |

## Verification
Two functions can fall in the same cycle. The first pair is the host's `done_clr` and the wrap that sets the completion flag. The bench drives the clear exactly onto the stop-bit wrap edge, which it computes from the reset-relative wrap phase, and expects the flag to read 1 afterwards.

The second pair is a byte write and a slice-counter wrap. Table rows place the write edge on a wrap and one edge before it. The bench then checks the whole `txd` waveform, cycle by cycle, against a start cycle computed from that phase.

// File: rtl/ser9_pkg.sv
package ser9_pkg;

    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = DATA_W + 3;
    localparam int SLICES     = 16;
    localparam int FCNT_W     = $clog2(FRAME_BITS + 1);

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_ARMED = 2'd1,
        TX_SEND = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic              ninth;
        logic [DATA_W-1:0] data;
    } tx_word_t;

    function automatic logic [FRAME_BITS-1:0] pack_frame(input tx_word_t w);
        return {1'b1, w.ninth, w.data, 1'b0};
    endfunction

endpackage

// File: rtl/ser9_baud_tick.sv
module ser9_baud_tick #(
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fast_rate,
    output logic tick
);
    localparam int DW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [DW-1:0] FAST_LAST = DW'(FAST_DIV - 1);
    localparam logic [DW-1:0] SLOW_LAST = DW'(SLOW_DIV - 1);

    logic [DW-1:0] div_q;
    logic [DW-1:0] last;

    always_comb begin
        last = fast_rate ? FAST_LAST : SLOW_LAST;
        tick = (div_q >= last);
    end

    always_ff @(posedge clk) begin
        if (rst)       div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R3

endmodule

// File: rtl/ser9_slice_cnt.sv
module ser9_slice_cnt #(
    parameter int SLICES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic wrap
);
    localparam int SW = $clog2(SLICES);
    localparam logic [SW-1:0] LAST = SW'(SLICES - 1);

    logic [SW-1:0] slice_q;

    assign wrap = tick && (slice_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)       slice_q <= '0;
        else if (tick) slice_q <= slice_q + 1'b1;
    end

    AST_WRAP_SPACED: assert property (@(posedge clk) disable iff (rst)
        wrap |=> !wrap); // R3

endmodule

// File: rtl/ser9_tx_frame.sv
module ser9_tx_frame
    import ser9_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wrap,
    input  logic     wr_stb,
    input  tx_word_t wr_word,
    input  logic     done_clr,
    output logic     txd,
    output logic     tx_done
);
    localparam logic [FCNT_W-1:0] LAST_IDX = FCNT_W'(FRAME_BITS - 1);

    tx_state_e               state_q;
    logic [FRAME_BITS-1:0]   shreg_q;
    logic [FCNT_W-1:0]       sent_q;
    logic                    txd_q;
    logic                    done_q;
    logic                    finish;

    assign finish  = wrap && (state_q == TX_SEND) && (sent_q == LAST_IDX);
    assign txd     = txd_q;
    assign tx_done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            shreg_q <= '1;
            sent_q  <= '0;
            txd_q   <= 1'b1;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (wr_stb) begin
                        shreg_q <= pack_frame(wr_word);
                        sent_q  <= '0;
                        state_q <= TX_ARMED;
                    end
                end
                TX_ARMED, TX_SEND: begin
                    if (wrap) begin
                        txd_q   <= shreg_q[0];
                        shreg_q <= {1'b1, shreg_q[FRAME_BITS-1:1]};
                        sent_q  <= sent_q + 1'b1;
                        state_q <= finish ? TX_IDLE : TX_SEND;
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           done_q <= 1'b0;
        else if (finish)   done_q <= 1'b1;
        else if (done_clr) done_q <= 1'b0;
    end

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_IDLE) |-> txd_q); // R1
    AST_TXD_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(txd_q)); // R3
    AST_ARMED_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_ARMED && !wrap) |=> txd_q); // R4
    AST_DONE_SET: assert property (@(posedge clk) disable iff (rst)
        finish |=> (done_q && txd_q)); // R5
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done_q && !done_clr) |=> done_q); // R6
    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && state_q != TX_IDLE && !wrap) |=> $stable(shreg_q)); // R8

endmodule

// File: rtl/ser9_tx.sv
module ser9_tx
    import ser9_pkg::*;
#(
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fast_rate,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bit9_in,
    input  logic              done_clr,
    output logic              txd,
    output logic              tx_done
);
    logic     tick;
    logic     wrap;
    tx_word_t word;

    assign word.ninth = bit9_in;
    assign word.data  = wr_data;

    ser9_baud_tick #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) i_tick (
        .clk       (clk),
        .rst       (rst),
        .fast_rate (fast_rate),
        .tick      (tick)
    );

    ser9_slice_cnt #(
        .SLICES (SLICES)
    ) i_slice (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .wrap (wrap)
    );

    ser9_tx_frame i_frame (
        .clk      (clk),
        .rst      (rst),
        .wrap     (wrap),
        .wr_stb   (wr_stb),
        .wr_word  (word),
        .done_clr (done_clr),
        .txd      (txd),
        .tx_done  (tx_done)
    );

endmodule

// File: tb/test_ser9_tx.sv
module test_ser9_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fast_rate = 1'b1;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       bit9_in = 1'b0;
    logic       done_clr = 1'b0;
    logic       txd;
    logic       tx_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    ser9_tx i_ser9_tx (
        .clk       (clk),
        .rst       (rst),
        .fast_rate (fast_rate),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .bit9_in   (bit9_in),
        .done_clr  (done_clr),
        .txd       (txd),
        .tx_done   (tx_done)
    );

    // fields: [19] fast, [18] ninth, [17:10] data, [9:2] write delay, [1] busy write, [0] clear collision
    localparam int NV = 8;
    localparam logic [19:0] VECS [NV] = '{
        {1'b1, 1'b1, 8'hA5, 8'd5,  1'b0, 1'b0},
        {1'b1, 1'b0, 8'h3C, 8'd30, 1'b0, 1'b0},
        {1'b1, 1'b1, 8'h01, 8'd31, 1'b1, 1'b0},
        {1'b0, 1'b0, 8'hF0, 8'd10, 1'b0, 1'b1},
        {1'b0, 1'b1, 8'h80, 8'd63, 1'b1, 1'b0},
        {1'b0, 1'b0, 8'h00, 8'd62, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'hFF, 8'd1,  1'b0, 1'b1},
        {1'b0, 1'b1, 8'h5A, 8'd100, 1'b1, 1'b1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic fast);
        rst = 1'b1;
        fast_rate = fast;
        wr_stb = 1'b0;
        done_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_vec(input logic [19:0] v);
        logic       fast  = v[19];
        logic       ninth = v[18];
        logic [7:0] data  = v[17:10];
        int         delay = int'(v[9:2]);
        bit         busy  = v[1];
        bit         coll  = v[0];
        int         per   = fast ? 32 : 64;
        logic [10:0] frame = {1'b1, ninth, data, 1'b0};
        int         w, cs, bad_t, bad_d, t_act, t_exp, d_act, d_exp;

        do_reset(fast);
        check(txd === 1'b1 && tx_done === 1'b0, "R1 reset state",
              int'({txd, tx_done}), 2);
        while (cyc < delay) @(negedge clk);
        w = cyc;
        wr_stb = 1'b1; wr_data = data; bit9_in = ninth;
        @(negedge clk);
        wr_stb = 1'b0; bit9_in = ~ninth; wr_data = ~data;
        cs = ((w + 2 + per - 1) / per) * per;
        bad_t = 0; bad_d = 0; t_act = 0; t_exp = 0; d_act = 0; d_exp = 0;
        while (cyc < cs + 11 * per) begin
            int  idx;
            logic et, ed;
            if (cyc < cs) et = 1'b1;
            else begin
                idx = (cyc - cs) / per;
                et = (idx > 10) ? 1'b1 : frame[idx];
            end
            ed = (cyc >= cs + 10 * per);
            if (txd !== et && bad_t == 0) begin bad_t = cyc; t_act = int'(txd); t_exp = int'(et); end
            if (tx_done !== ed && bad_d == 0) begin bad_d = cyc; d_act = int'(tx_done); d_exp = int'(ed); end
            wr_stb = busy && (cyc == cs + 3 * per + 5);
            done_clr = coll && (cyc == cs + 10 * per - 1);
            @(negedge clk);
        end
        wr_stb = 1'b0; done_clr = 1'b0;
        // R2 R3 R4 R9: full waveform, cycle by cycle
        check(bad_t == 0, $sformatf("R2 R3 R4 R9 txd waveform at cyc %0d", bad_t), t_act, t_exp);
        check(bad_d == 0, $sformatf("R5 done timing at cyc %0d", bad_d), d_act, d_exp);
        if (busy) check(bad_t == 0, "R8 busy write ignored", t_act, t_exp);
        if (coll) check(tx_done === 1'b1, "R7 set beats clear", int'(tx_done), 1);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R6: flag holds, then clears one cycle after done_clr
        repeat (40) @(negedge clk);
        check(tx_done === 1'b1, "R6 done holds", int'(tx_done), 1);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        check(tx_done === 1'b0, "R6 done cleared", int'(tx_done), 0);
        check(txd === 1'b1, "R2 line idle after frame", int'(txd), 1);

        // R1: idle with no write for several bit times
        do_reset(1'b1);
        repeat (100) @(negedge clk);
        check(txd === 1'b1 && tx_done === 1'b0, "R1 idle without write",
              int'({txd, tx_done}), 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule